// File: doc/BRIEF.md
# Key-Protected Clock Prescaler Controller

This block sits on a simple byte-wide register bus and produces a clock-enable pulse that divides the incoming clock by a selectable ratio. The ratio set covers binary divisions from 2 to 64. It also covers non-binary divisions of 6, 10, 12, 24 and 48. Software cannot change the prescaler setting with a plain write. It must first store an unlock key in a guard register. This opens a four-cycle window in which exactly one protected write is honoured. A freeze bit, itself protected, can make the setting permanent until the next reset.

The unlock logic is a two-state machine, `WIN_SHUT` and `WIN_ARMED`:

- **SHUT → ARMED**: a key write opens the window.
- **ARMED → ARMED**: a repeated key write reloads the window.
- **ARMED → SHUT, wrong key**: a write of any other value to the guard register closes the window.
- **ARMED → SHUT, protected write**: an access to a protected register closes the window.
- **ARMED → SHUT, timeout**: the fourth cycle after the key passes with no protected write.

The divider runs in two named modes. In `DIV_PASS` the enable is high on every cycle. In `DIV_COUNT` it pulses once every N cycles. A new ratio or mode is adopted only on a pulse, so no period is ever cut short.

Register map, byte-wide:

| Address | Register | Write | Read |
|---|---|---|---|
| 0 | Guard | unlock key | bit 0 = window open; bits 7:1 = 0 |
| 1 | Config | protected; bit 0 = divide enable, bits 4:1 = ratio code | same layout |
| 2 | Freeze | protected; bit 0 = freeze | bit 0 = freeze |
| 3 | Reserved | ignored | zero |

Top module: `prot_clkdiv_ctrl`

## Requirements
- R1: Writing 0xD8 to address 0 opens the unlock window. While the window is open, address 0 reads back bit 0 as 1.
- R2: A protected write is accepted if it is committed in any of the four cycles that follow the key write. A protected write committed in the fifth cycle is ignored.
- R3: A write to address 1 or 2 while no window is open is ignored, and the register keeps its value.
- R4: The config register holds the divide enable in bit 0 and the ratio code in bits 4:1. When the enable is 0, `clk_en_o` is high on every cycle.
- R5: After reset, the config register reads 0x11 (enable 1, code 0x8, divide by 6). The freeze bit reads 0, and the guard register reads 0x00.
- R6: The ratio codes are 0x0=/2, 0x1=/4, 0x2=/8, 0x3=/16, 0x4=/32, 0x5=/64, 0x8=/6, 0x9=/10, 0xA=/12, 0xB=/24 and 0xC=/48. Any other code divides by 2.
- R7: A protected write of 1 to bit 0 of address 2 sets the freeze bit. Once it is set, config writes are ignored even inside a window, and the freeze bit stays 1 until reset.
- R8: Writing any value other than 0xD8 to address 0 closes an open window.
- R9: An accepted protected write closes the window, so each key allows one write only.
- R10: `clk_en_o` is a one-cycle pulse every N cycles. A new setting takes effect at the next pulse, and the period in progress completes at the old ratio.
- R11: Bits 7:1 of address 0 always read 0, and the key value is never read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Write strobe, committed on the rising edge |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Combinational read data for `bus_addr_i` |
| clk_en_o | output | 1 | Divided clock-enable pulse |

## Verification
A wrong window state is visible on the next cycle. The guard status bit reads back the window state directly. A protected write placed one cycle after the window should have closed lands, or is dropped, one cycle later, and the config read-back shows this at once. Faults in the divider show at the first `clk_en_o` interval after a pulse. A wrong decode, or a setting adopted mid-period, gives an interval length different from the expected one. A freeze bit that is not sticky shows as a config value that changes after a locked write.

// File: rtl/prot_clkdiv_pkg.sv
package prot_clkdiv_pkg;

    localparam int DATA_W = 8;
    localparam int CODE_W = 4;
    localparam int DIV_W  = 7;

    typedef enum logic [0:0] {
        WIN_SHUT  = 1'b0,
        WIN_ARMED = 1'b1
    } win_state_e;

    typedef enum logic [0:0] {
        DIV_PASS  = 1'b0,
        DIV_COUNT = 1'b1
    } div_mode_e;

    function automatic logic [DIV_W-1:0] ratio_of(input logic [CODE_W-1:0] code);
        logic [DIV_W-1:0] n;
        unique case (code)
            4'h0:    n = 7'd2;
            4'h1:    n = 7'd4;
            4'h2:    n = 7'd8;
            4'h3:    n = 7'd16;
            4'h4:    n = 7'd32;
            4'h5:    n = 7'd64;
            4'h8:    n = 7'd6;
            4'h9:    n = 7'd10;
            4'hA:    n = 7'd12;
            4'hB:    n = 7'd24;
            4'hC:    n = 7'd48;
            default: n = 7'd2;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/prot_window_fsm.sv
module prot_window_fsm
    import prot_clkdiv_pkg::*;
#(
    parameter int WINDOW_CYC = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic guard_wr_i,
    input  logic key_match_i,
    input  logic prot_wr_i,
    output logic win_open_o,
    output logic grant_o
);

    localparam int CNT_W = $clog2(WINDOW_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WINDOW_CYC);

    win_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            WIN_SHUT: begin
                if (guard_wr_i && key_match_i) begin
                    state_d = WIN_ARMED;
                    cnt_d   = CNT_LOAD;
                end
            end
            WIN_ARMED: begin
                if (guard_wr_i) begin
                    if (key_match_i) begin
                        cnt_d = CNT_LOAD;
                    end else begin
                        state_d = WIN_SHUT;
                        cnt_d   = '0;
                    end
                end else if (prot_wr_i || cnt_q == CNT_W'(1)) begin
                    state_d = WIN_SHUT;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            default: begin
                state_d = WIN_SHUT;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= WIN_SHUT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        win_open_o = (state_q == WIN_ARMED);
        grant_o    = (state_q == WIN_ARMED) && prot_wr_i;
    end

    assert_key_opens_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (guard_wr_i && key_match_i) |=> win_open_o);

    assert_wrong_key_closes_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (guard_wr_i && !key_match_i) |=> !win_open_o);

    assert_single_grant_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        grant_o |=> !win_open_o);

    assert_window_nonzero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        win_open_o |-> (cnt_q != '0));

endmodule

// File: rtl/prot_ctrl_regs.sv
module prot_ctrl_regs
    import prot_clkdiv_pkg::*;
#(
    parameter int               ADDR_W   = 2,
    parameter logic [CODE_W-1:0] RST_CODE = 4'h8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              grant_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CODE_W:0]   wfield_i,
    output logic              div_en_o,
    output logic [CODE_W-1:0] div_code_o,
    output logic              freeze_o
);

    localparam logic [ADDR_W-1:0] CFG_ADDR    = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] FREEZE_ADDR = ADDR_W'(2);

    logic              en_q;
    logic [CODE_W-1:0] code_q;
    logic              frz_q;
    logic              cfg_wr, frz_set;

    always_comb begin
        cfg_wr  = grant_i && (addr_i == CFG_ADDR) && !frz_q;
        frz_set = grant_i && (addr_i == FREEZE_ADDR) && wfield_i[0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_q   <= 1'b1;
            code_q <= RST_CODE;
            frz_q  <= 1'b0;
        end else begin
            if (cfg_wr) begin
                en_q   <= wfield_i[0];
                code_q <= wfield_i[CODE_W:1];
            end
            if (frz_set) begin
                frz_q <= 1'b1;
            end
        end
    end

    assign div_en_o   = en_q;
    assign div_code_o = code_q;
    assign freeze_o   = frz_q;

    assert_no_grant_no_change_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !grant_i |=> ($stable(en_q) && $stable(code_q)));

    assert_freeze_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frz_q |=> frz_q);

    assert_frozen_cfg_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frz_q |=> ($stable(en_q) && $stable(code_q)));

endmodule

// File: rtl/prot_tick_gen.sv
module prot_tick_gen
    import prot_clkdiv_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              div_en_i,
    input  logic [CODE_W-1:0] div_code_i,
    input  logic [DIV_W-1:0]  rst_ratio_i,
    output logic              tick_o
);

    div_mode_e        mode_q;
    logic [DIV_W-1:0] ratio_q;
    logic [DIV_W-1:0] cnt_q;
    logic             tick;

    always_comb begin
        unique case (mode_q)
            DIV_PASS:  tick = 1'b1;
            DIV_COUNT: tick = (cnt_q == ratio_q - DIV_W'(1));
            default:   tick = 1'b1;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mode_q  <= DIV_COUNT;
            ratio_q <= rst_ratio_i;
            cnt_q   <= '0;
        end else if (tick) begin
            cnt_q   <= '0;
            mode_q  <= div_en_i ? DIV_COUNT : DIV_PASS;
            ratio_q <= ratio_of(div_code_i);
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    assign tick_o = tick;

    assert_switch_on_boundary_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick |=> ($stable(ratio_q) && $stable(mode_q)));

    assert_count_in_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_q == DIV_COUNT) |-> (cnt_q < ratio_q));

endmodule

// File: rtl/prot_clkdiv_ctrl.sv
module prot_clkdiv_ctrl
    import prot_clkdiv_pkg::*;
#(
    parameter int                ADDR_W     = 2,
    parameter logic [DATA_W-1:0] UNLOCK_KEY = 8'hD8,
    parameter int                WINDOW_CYC = 4,
    parameter logic [CODE_W-1:0] RST_CODE   = 4'h8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              clk_en_o
);

    localparam logic [ADDR_W-1:0] GUARD_ADDR  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] CFG_ADDR    = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] FREEZE_ADDR = ADDR_W'(2);
    localparam logic [DIV_W-1:0]  RST_RATIO   = ratio_of(RST_CODE);

    logic              guard_wr, key_match, prot_wr;
    logic              win_open, grant;
    logic              div_en, freeze;
    logic [CODE_W-1:0] div_code;

    always_comb begin
        guard_wr  = bus_we_i && (bus_addr_i == GUARD_ADDR);
        key_match = (bus_wdata_i == UNLOCK_KEY);
        prot_wr   = bus_we_i && ((bus_addr_i == CFG_ADDR) || (bus_addr_i == FREEZE_ADDR));
    end

    prot_window_fsm #(.WINDOW_CYC(WINDOW_CYC)) u_window (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .guard_wr_i  (guard_wr),
        .key_match_i (key_match),
        .prot_wr_i   (prot_wr),
        .win_open_o  (win_open),
        .grant_o     (grant)
    );

    prot_ctrl_regs #(.ADDR_W(ADDR_W), .RST_CODE(RST_CODE)) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .grant_i    (grant),
        .addr_i     (bus_addr_i),
        .wfield_i   (bus_wdata_i[CODE_W:0]),
        .div_en_o   (div_en),
        .div_code_o (div_code),
        .freeze_o   (freeze)
    );

    prot_tick_gen u_tick (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .div_en_i    (div_en),
        .div_code_i  (div_code),
        .rst_ratio_i (RST_RATIO),
        .tick_o      (clk_en_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        unique case (bus_addr_i)
            GUARD_ADDR:  bus_rdata_o[0] = win_open;
            CFG_ADDR:    bus_rdata_o[CODE_W:0] = {div_code, div_en};
            FREEZE_ADDR: bus_rdata_o[0] = freeze;
            default:     bus_rdata_o = '0;
        endcase
    end

    assert_guard_reads_status_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_addr_i == GUARD_ADDR) |-> (bus_rdata_o[DATA_W-1:1] == '0));

    assert_closed_write_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (prot_wr && !win_open) |=> ($stable(div_en) && $stable(div_code) && $stable(freeze)));

endmodule

// File: tb/prot_clkdiv_ctrl_bench.sv
`timescale 1ns/1ps
module prot_clkdiv_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       clk_en;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    prot_clkdiv_ctrl u_prot_clkdiv_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .clk_en_o(clk_en)
    );

    initial begin
        #4_000_000;
        n_errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic int rd(input logic [1:0] a);
        addr = a;
        return 0;
    endfunction

    task automatic read(input logic [1:0] a, output int v);
        int unused;
        unused = rd(a);
        #1 v = int'(rdata);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; we = 1'b0;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic prot_wr(input logic [1:0] a, input logic [7:0] d);
        wr(2'd0, 8'hD8);
        wr(a, d);
    endtask

    task automatic sync_pulse();
        for (int i = 0; i < 200 && !clk_en; i++) @(negedge clk);
    endtask

    task automatic measure(output int n);
        sync_pulse();
        n = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            n++;
            if (clk_en) break;
        end
    endtask

    task automatic t_reset();
        int v;
        read(2'd1, v); check("R5 cfg reset", v, 8'h11);
        read(2'd2, v); check("R5 freeze reset", v, 0);
        read(2'd0, v); check("R5 guard reset", v, 0);
        measure(v);    check("R5 reset period /6", v, 6);
    endtask

    task automatic t_key_status();
        int v;
        wr(2'd0, 8'hD8);
        read(2'd0, v); check("R1 status after key", v, 1);
        check("R11 key not read back", v & 8'hFE, 0);
        idle(4);
        read(2'd0, v); check("R2 status after timeout", v, 0);
    endtask

    task automatic t_no_window();
        int v;
        wr(2'd1, 8'h03);
        read(2'd1, v); check("R3 cfg unchanged", v, 8'h11);
        wr(2'd2, 8'h01);
        read(2'd2, v); check("R3 freeze unchanged", v, 0);
    endtask

    task automatic t_window_edge();
        int v;
        wr(2'd0, 8'hD8); idle(3); wr(2'd1, 8'h05);
        read(2'd1, v); check("R2 fourth cycle accepted", v, 8'h05);
        wr(2'd0, 8'hD8); idle(4); wr(2'd1, 8'h07);
        read(2'd1, v); check("R2 fifth cycle ignored", v, 8'h05);
    endtask

    task automatic t_wrong_key();
        int v;
        wr(2'd0, 8'hD8); wr(2'd0, 8'h5A);
        read(2'd0, v); check("R8 status closed", v, 0);
        wr(2'd1, 8'h07);
        read(2'd1, v); check("R8 cfg unchanged", v, 8'h05);
    endtask

    task automatic t_one_write();
        int v;
        wr(2'd0, 8'hD8); wr(2'd1, 8'h13); wr(2'd1, 8'h15);
        read(2'd1, v); check("R9 only first write", v, 8'h13);
        read(2'd0, v); check("R9 window closed", v, 0);
    endtask

    task automatic t_ratios();
        int v;
        int codes[12] = '{0, 1, 2, 3, 4, 5, 8, 9, 10, 11, 12, 6};
        int exps[12]  = '{2, 4, 8, 16, 32, 64, 6, 10, 12, 24, 48, 2};
        foreach (codes[i]) begin
            prot_wr(2'd1, 8'((codes[i] << 1) | 1));
            measure(v); measure(v);
            check($sformatf("R6 code 0x%0h", codes[i]), v, exps[i]);
        end
    endtask

    task automatic t_passthrough();
        int v;
        prot_wr(2'd1, 8'h14);
        measure(v); measure(v);
        check("R4 enable clear divides by 1", v, 1);
        read(2'd1, v); check("R4 field layout", v, 8'h14);
    endtask

    task automatic t_boundary();
        int v;
        prot_wr(2'd1, 8'h11);
        measure(v); measure(v);
        check("R10 steady /6", v, 6);
        sync_pulse();
        prot_wr(2'd1, 8'h01);
        idle(3);
        check("R10 no pulse mid-period", int'(clk_en), 0);
        idle(1);
        check("R10 old period completes", int'(clk_en), 1);
        measure(v);
        check("R10 new period /2", v, 2);
    endtask

    task automatic t_freeze();
        int v;
        prot_wr(2'd2, 8'h01);
        read(2'd2, v); check("R7 freeze set", v, 1);
        prot_wr(2'd1, 8'h17);
        read(2'd1, v); check("R7 cfg frozen", v, 8'h01);
        prot_wr(2'd2, 8'h00);
        read(2'd2, v); check("R7 freeze sticky", v, 1);
        do_reset();
        read(2'd2, v); check("R7 freeze cleared by reset", v, 0);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_key_status();
        t_no_window();
        t_window_edge();
        t_wrong_key();
        t_one_write();
        t_ratios();
        t_passthrough();
        t_boundary();
        t_freeze();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule